// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block collects interrupt requests from a parameterized number of peripheral lines and from one non-maskable source. It presents the CPU with a single registered request that carries a vector index. Each line holds an enable flag, a pending flag, an active flag and a priority level. Software reaches all of them through a byte-wide register port that writes on a clock edge and reads combinationally. A smaller priority number is more urgent, and level 0 is the most urgent.

Three controls decide whether a pending line may reach the CPU. A grouping value splits the priority into a preemption part and a subpriority part. A base-priority threshold masks the less urgent levels. A global disable holds back every maskable request. The non-maskable source ignores all three. When the CPU accepts a request, the line moves from pending to active. When the CPU reports completion, the active flag clears. While lines are active, the most urgent active level is the running priority. A new request can interrupt the running code only when its preemption part is strictly more urgent than that level.

Register addresses are `{space[1:0], sel}`:
- Space 0 is per-line control.
- Space 1 is per-line priority.
- Space 2 holds the global controls.
- Space 3 reads as zero.

Top module: `pnic_top`

## Requirements
- R1: After reset, `req_valid` is 0. Every line control read, every priority read and every global read returns 0.
- R2: A priority write keeps only the top PRI_W bits of the byte (bits 7:5 with the defaults). A read returns level k as k<<5, with the lower five bits reading 0.
- R3: Among eligible lines, the numerically smallest priority wins, and on equal priority the lowest index wins. The request is registered: it appears one clock after the state that makes it eligible. It stays unchanged until it is acknowledged or a more urgent eligible request takes its place.
- R4: A line whose enable is 0 keeps its pending flag and raises no request. Control writes use these bits: bit0 sets enable, bit1 clears enable, bit2 sets pending, bit3 clears pending. Control reads return bit0 enable, bit1 pending, bit2 active. Setting the enable later produces the request.
- R5: `ack_in` accepts the presented vector. `req_valid` is 0 in the following cycle, and the line's pending flag clears while its active flag sets.
- R6: A line's `irq_in` bit sampled high on a clock edge sets its pending flag, and so does a software set. A software clear discards the unserviced request, so a later enable raises nothing.
- R7: The base threshold is global sel 1, bits PRI_W-1:0. A value of 0 masks nothing. A value M from 1 upward blocks every line whose priority is M or larger.
- R8: The global disable is global sel 2, bit 0. While it is set, no maskable request reaches the CPU, and the enable flags are left as they were.
- R9: The grouping value is global sel 0, bits 2:0. With g = min(G, PRI_W), a line preempts active work only if its top g priority bits are numerically smaller than those of the running priority.
- R10: Grouping values from PRI_W up to 7 behave the same way. Grouping 0 never lets a request preempt while any line is active.
- R11: The non-maskable source lives at global sel 3. A write of bit0 pends it, and a read returns bit0 pending and bit1 active. It is requested the cycle after it pends, regardless of the mask, the disable or active lines. No write can clear its pending flag. While it is active, no maskable request is raised.
- R12: `done_in` clears the active flag of the line in `done_idx`, or of the non-maskable source when `done_nmi` is set. The running priority is then recomputed, so blocked lines can be requested again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_LINES | Peripheral request lines, sampled each edge |
| nmi_in | input | 1 | Non-maskable request, sampled each edge |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+2 | Register address {space, sel} |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| req_valid | output | 1 | Request to the CPU |
| req_nmi | output | 1 | Presented request is the non-maskable source |
| req_idx | output | IDX_W | Line index of the presented request |
| ack_in | input | 1 | CPU accepts the presented request |
| done_in | input | 1 | CPU completion pulse |
| done_nmi | input | 1 | Completion refers to the non-maskable source |
| done_idx | input | IDX_W | Line index being completed |

## Verification
A corrupted pending, active or priority flag appears at the ports within one clock. It shows either as a request for the wrong index or as a missing or extra `req_valid` after the next state change, or as a wrong bit in a control read. A wrong running priority is subtler: it only shows when a second line pends during active work. For that reason the grouping sweep pairs every running level with every new level under every grouping value. The mask sweep walks every threshold against every level, so an off-by-one comparison shows up as a single wrong request bit.

// File: rtl/pnic_pkg.sv
package pnic_pkg;

   typedef enum logic [1:0] {
      SPACE_LINE = 2'd0,
      SPACE_PRIO = 2'd1,
      SPACE_GLOB = 2'd2,
      SPACE_NONE = 2'd3
   } space_e;

   // control write bits
   localparam int CTL_EN_SET = 0;
   localparam int CTL_EN_CLR = 1;
   localparam int CTL_PD_SET = 2;
   localparam int CTL_PD_CLR = 3;

   // global selectors
   localparam int GLB_GROUP = 0;
   localparam int GLB_BASE  = 1;
   localparam int GLB_GDIS  = 2;
   localparam int GLB_NMI   = 3;

   localparam int BYTE_W = 8;

   function automatic int idx_width(input int n);
      return ($clog2(n) < 2) ? 2 : $clog2(n);
   endfunction

endpackage

// File: rtl/pnic_line_bank.sv
module pnic_line_bank
   import pnic_pkg::*;
#(
   parameter int N_LINES = 8,
   parameter int PRI_W   = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [N_LINES-1:0]              irq_in,
   input  logic [N_LINES-1:0]              wr_ctl,
   input  logic [N_LINES-1:0]              wr_pri,
   input  logic [3:0]                      ctl_bits,
   input  logic [PRI_W-1:0]                pri_bits,
   input  logic [N_LINES-1:0]              ack_line,
   input  logic [N_LINES-1:0]              done_line,
   output logic [N_LINES-1:0]              en,
   output logic [N_LINES-1:0]              pend,
   output logic [N_LINES-1:0]              act,
   output logic [N_LINES-1:0][PRI_W-1:0]   prio
);

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      logic             en_r, pend_r, act_r;
      logic [PRI_W-1:0] prio_r;
      logic             set_en, clr_en, set_pd, clr_pd;

      assign set_en = wr_ctl[i] & ctl_bits[CTL_EN_SET];
      assign clr_en = wr_ctl[i] & ctl_bits[CTL_EN_CLR];
      assign set_pd = wr_ctl[i] & ctl_bits[CTL_PD_SET];
      assign clr_pd = wr_ctl[i] & ctl_bits[CTL_PD_CLR];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_r   <= 1'b0;
            pend_r <= 1'b0;
            act_r  <= 1'b0;
            prio_r <= '0;
         end else begin
            en_r   <= (en_r | set_en) & ~clr_en;
            pend_r <= (pend_r & ~ack_line[i] & ~clr_pd) | irq_in[i] | set_pd;
            act_r  <= (act_r & ~done_line[i]) | ack_line[i];
            if (wr_pri[i]) prio_r <= pri_bits;
         end
      end

      assign en[i]   = en_r;
      assign pend[i] = pend_r;
      assign act[i]  = act_r;
      assign prio[i] = prio_r;

      AST_PEND_CLR_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
         ack_line[i] && !irq_in[i] && !set_pd |=> !pend_r); // R5
      AST_ACT_SET_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
         ack_line[i] |=> act_r); // R5
      AST_ACT_CLR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
         done_line[i] && !ack_line[i] |=> !act_r); // R12
   end

endmodule

// File: rtl/pnic_arbiter.sv
module pnic_arbiter
   import pnic_pkg::*;
#(
   parameter int N_LINES = 8,
   parameter int PRI_W   = 3,
   localparam int IDX_W  = idx_width(N_LINES)
) (
   input  logic [N_LINES-1:0]              cand,
   input  logic [N_LINES-1:0][PRI_W-1:0]   prio,
   input  logic [N_LINES-1:0]              act,
   input  logic [2:0]                      grp,
   input  logic [PRI_W-1:0]                base,
   input  logic                            blocked,
   output logic [N_LINES-1:0]              allow,
   output logic                            win_found,
   output logic [IDX_W-1:0]                win_idx
);

   logic [PRI_W-1:0]   gmask;
   logic               run_found;
   logic [PRI_W-1:0]   run_prio;
   logic [N_LINES-1:0] elig;

   // preemption part: top min(grp, PRI_W) bits of the priority
   always_comb begin : p_gmask
      int gb;
      gb = (int'(grp) > PRI_W) ? PRI_W : int'(grp);
      for (int j = 0; j < PRI_W; j++) gmask[j] = (j >= PRI_W - gb);
   end

   // running priority: most urgent active line
   always_comb begin
      run_found = 1'b0;
      run_prio  = '1;
      for (int i = 0; i < N_LINES; i++) begin
         if (act[i] && (!run_found || prio[i] < run_prio)) begin
            run_found = 1'b1;
            run_prio  = prio[i];
         end
      end
   end

   for (genvar i = 0; i < N_LINES; i++) begin : g_elig
      assign allow[i] = (base == '0) || (prio[i] < base);
      assign elig[i]  = cand[i] & allow[i] & ~blocked &
                        (~run_found | ((prio[i] & gmask) < (run_prio & gmask)));
   end

   // strict compare keeps the lowest index on equal priority
   always_comb begin : p_pick
      logic [PRI_W-1:0] best;
      best      = '1;
      win_found = 1'b0;
      win_idx   = '0;
      for (int i = 0; i < N_LINES; i++) begin
         if (elig[i] && (!win_found || prio[i] < best)) begin
            win_found = 1'b1;
            best      = prio[i];
            win_idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/pnic_top.sv
module pnic_top
   import pnic_pkg::*;
#(
   parameter int N_LINES = 8,
   parameter int PRI_W   = 3,
   localparam int IDX_W  = idx_width(N_LINES),
   localparam int ADDR_W = IDX_W + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] irq_in,
   input  logic               nmi_in,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [7:0]         reg_wdata,
   output logic [7:0]         reg_rdata,
   output logic               req_valid,
   output logic               req_nmi,
   output logic [IDX_W-1:0]   req_idx,
   input  logic               ack_in,
   input  logic               done_in,
   input  logic               done_nmi,
   input  logic [IDX_W-1:0]   done_idx
);

   if (N_LINES < 2 || N_LINES > 256) begin : g_bad_lines
      $fatal(1, "pnic_top: N_LINES must be 2..256");
   end
   if (PRI_W < 1 || PRI_W > BYTE_W) begin : g_bad_pri
      $fatal(1, "pnic_top: PRI_W must be 1..8");
   end

   space_e           space;
   logic [IDX_W-1:0] sel;
   logic             unused_wdata;

   assign space        = space_e'(reg_addr[ADDR_W-1 -: 2]);
   assign sel          = reg_addr[IDX_W-1:0];
   assign unused_wdata = ^reg_wdata;

   logic [N_LINES-1:0] wr_ctl, wr_pri, ack_line, done_line;
   logic               ack_nmi, wr_glb;

   assign wr_glb  = reg_we && (space == SPACE_GLOB);
   assign ack_nmi = ack_in && req_valid && req_nmi;

   always_comb begin
      for (int i = 0; i < N_LINES; i++) begin
         wr_ctl[i]    = reg_we && (space == SPACE_LINE) && (sel == IDX_W'(i));
         wr_pri[i]    = reg_we && (space == SPACE_PRIO) && (sel == IDX_W'(i));
         ack_line[i]  = ack_in && req_valid && !req_nmi && (req_idx == IDX_W'(i));
         done_line[i] = done_in && !done_nmi && (done_idx == IDX_W'(i));
      end
   end

   // global controls
   logic [2:0]       grp_q;
   logic [PRI_W-1:0] base_q;
   logic             gdis_q, nmi_pend_q, nmi_act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_q      <= '0;
         base_q     <= '0;
         gdis_q     <= 1'b0;
         nmi_pend_q <= 1'b0;
         nmi_act_q  <= 1'b0;
      end else begin
         if (wr_glb && sel == IDX_W'(GLB_GROUP)) grp_q  <= reg_wdata[2:0];
         if (wr_glb && sel == IDX_W'(GLB_BASE))  base_q <= reg_wdata[PRI_W-1:0];
         if (wr_glb && sel == IDX_W'(GLB_GDIS))  gdis_q <= reg_wdata[0];
         nmi_pend_q <= (nmi_pend_q & ~ack_nmi) | nmi_in |
                       (wr_glb && sel == IDX_W'(GLB_NMI) && reg_wdata[0]);
         nmi_act_q  <= (nmi_act_q & ~(done_in & done_nmi)) | ack_nmi;
      end
   end

   logic [N_LINES-1:0]            en_v, pend_v, act_v, allow_v;
   logic [N_LINES-1:0][PRI_W-1:0] prio_v;
   logic                          win_found;
   logic [IDX_W-1:0]              win_idx;

   pnic_line_bank #(.N_LINES(N_LINES), .PRI_W(PRI_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .wr_ctl    (wr_ctl),
      .wr_pri    (wr_pri),
      .ctl_bits  (reg_wdata[3:0]),
      .pri_bits  (reg_wdata[BYTE_W-1 -: PRI_W]),
      .ack_line  (ack_line),
      .done_line (done_line),
      .en        (en_v),
      .pend      (pend_v),
      .act       (act_v),
      .prio      (prio_v)
   );

   pnic_arbiter #(.N_LINES(N_LINES), .PRI_W(PRI_W)) u_arb (
      .cand      (pend_v & en_v & ~act_v),
      .prio      (prio_v),
      .act       (act_v),
      .grp       (grp_q),
      .base      (base_q),
      .blocked   (nmi_act_q),
      .allow     (allow_v),
      .win_found (win_found),
      .win_idx   (win_idx)
   );

   // registered request; an acknowledge forces one idle cycle
   logic             nx_v, nx_nmi;
   logic [IDX_W-1:0] nx_idx;

   always_comb begin
      nx_v   = 1'b0;
      nx_nmi = 1'b0;
      nx_idx = '0;
      if (!ack_in) begin
         if (nmi_pend_q && !nmi_act_q) begin
            nx_v   = 1'b1;
            nx_nmi = 1'b1;
         end else if (win_found && !gdis_q) begin
            nx_v   = 1'b1;
            nx_idx = win_idx;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_nmi   <= 1'b0;
         req_idx   <= '0;
      end else begin
         req_valid <= nx_v;
         req_nmi   <= nx_nmi;
         req_idx   <= nx_idx;
      end
   end

   // register read
   always_comb begin
      reg_rdata = '0;
      case (space)
         SPACE_LINE: begin
            for (int i = 0; i < N_LINES; i++)
               if (sel == IDX_W'(i)) reg_rdata[2:0] = {act_v[i], pend_v[i], en_v[i]};
         end
         SPACE_PRIO: begin
            for (int i = 0; i < N_LINES; i++)
               if (sel == IDX_W'(i)) reg_rdata[BYTE_W-1 -: PRI_W] = prio_v[i];
         end
         SPACE_GLOB: begin
            if (sel == IDX_W'(GLB_GROUP)) reg_rdata[2:0]       = grp_q;
            if (sel == IDX_W'(GLB_BASE))  reg_rdata[PRI_W-1:0] = base_q;
            if (sel == IDX_W'(GLB_GDIS))  reg_rdata[0]         = gdis_q;
            if (sel == IDX_W'(GLB_NMI))   reg_rdata[1:0]       = {nmi_act_q, nmi_pend_q};
         end
         default: reg_rdata = '0;
      endcase
   end

   // one-cycle-delayed views for request checks
   logic [N_LINES-1:0] chk_ready_d, chk_allow_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_ready_d <= '0;
         chk_allow_d <= '0;
      end else begin
         chk_ready_d <= pend_v & en_v;
         chk_allow_d <= allow_v;
      end
   end

   AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ack_in |-> req_valid); // R5
   AST_REQ_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ack_in |=> !req_valid); // R5
   AST_REQ_LINE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_nmi |-> chk_ready_d[req_idx]); // R4
   AST_REQ_UNDER_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_nmi |-> chk_allow_d[req_idx]); // R7
   AST_GDIS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(gdis_q) |-> !(req_valid && !req_nmi)); // R8
   AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pend_q && !nmi_act_q && !ack_in |=> req_valid && req_nmi); // R11
   AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pend_q && !ack_nmi |=> nmi_pend_q); // R11
   AST_NMI_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(nmi_act_q) |-> !(req_valid && !req_nmi)); // R11

endmodule

// File: tb/sim_pnic_top.sv
module sim_pnic_top;

   localparam int N  = 8;
   localparam int IW = 3;
   localparam int AW = 5;
   localparam int SP_LINE = 0, SP_PRIO = 1, SP_GLOB = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in = '0;
   logic          nmi_in = 1'b0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic          req_valid, req_nmi;
   logic [IW-1:0] req_idx;
   logic          ack_in = 1'b0, done_in = 1'b0, done_nmi = 1'b0;
   logic [IW-1:0] done_idx = '0;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pnic_top #(.N_LINES(N), .PRI_W(3)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_nmi(req_nmi), .req_idx(req_idx),
      .ack_in(ack_in), .done_in(done_in), .done_nmi(done_nmi), .done_idx(done_idx)
   );

   function automatic logic [AW-1:0] ad(input int sp, input int s);
      return AW'(sp * 8 + s);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input int sp, input int s, input logic [7:0] d);
      reg_we = 1'b1; reg_addr = ad(sp, s); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rdchk(input int sp, input int s, input int exp, input string tag);
      reg_addr = ad(sp, s);
      #1;
      chk(reg_rdata == 8'(exp), tag, reg_rdata, exp);
   endtask

   task automatic reqchk(input bit v, input bit nm, input int idx, input string tag);
      bit ok;
      ok = (req_valid == v) && (!v || (req_nmi == nm && int'(req_idx) == idx));
      chk(ok, tag, {req_valid, req_nmi, req_idx}, {v, nm, 3'(idx)});
   endtask

   task automatic ack();
      ack_in = 1'b1;
      @(negedge clk);
      ack_in = 1'b0;
   endtask

   task automatic done(input int idx, input bit nm);
      done_in = 1'b1; done_nmi = nm; done_idx = IW'(idx);
      @(negedge clk);
      done_in = 1'b0; done_nmi = 1'b0;
   endtask

   initial begin : watchdog
      #2_000_000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      reqchk(0, 0, 0, "R1 req after reset");
      for (int i = 0; i < N; i++) rdchk(SP_LINE, i, 0, "R1 line ctl");
      for (int i = 0; i < N; i++) rdchk(SP_PRIO, i, 0, "R1 prio");
      for (int s = 0; s < 4; s++) rdchk(SP_GLOB, s, 0, "R1 global");

      // R2 priority field
      wr(SP_PRIO, 2, 8'hFF); rdchk(SP_PRIO, 2, 8'hE0, "R2 write FF");
      wr(SP_PRIO, 2, 8'h5A); rdchk(SP_PRIO, 2, 8'h40, "R2 write 5A");
      wr(SP_PRIO, 2, 8'h3F); rdchk(SP_PRIO, 2, 8'h20, "R2 write 3F");
      wr(SP_PRIO, 2, 8'h00);

      // R3 arbitration, tie break, latency
      wr(SP_PRIO, 3, 8'h80); wr(SP_PRIO, 5, 8'h40); wr(SP_PRIO, 6, 8'h40);
      wr(SP_LINE, 3, 8'h05); wr(SP_LINE, 5, 8'h05);
      tick();
      reqchk(1, 0, 5, "R3 smaller prio wins");
      wr(SP_LINE, 6, 8'h05);
      tick();
      reqchk(1, 0, 5, "R3 tie lowest index");
      wr(SP_PRIO, 1, 8'h00); wr(SP_LINE, 1, 8'h05);
      reqchk(1, 0, 5, "R3 held before update");
      tick();
      reqchk(1, 0, 1, "R3 superseded");
      for (int i = 0; i < N; i++) wr(SP_LINE, i, 8'h0A);
      tick();
      reqchk(0, 0, 0, "R3 cleared");

      // R5 acknowledge, R12 completion
      wr(SP_PRIO, 4, 8'h60); wr(SP_LINE, 4, 8'h05);
      tick();
      reqchk(1, 0, 4, "R5 request line4");
      ack();
      reqchk(0, 0, 0, "R5 drop after ack");
      rdchk(SP_LINE, 4, 8'h05, "R5 pend clr act set");
      tick();
      reqchk(0, 0, 0, "R5 no rerequest");
      done(4, 0);
      rdchk(SP_LINE, 4, 8'h01, "R12 active cleared");
      wr(SP_LINE, 4, 8'h02);

      // R4 disabled line stays pending
      wr(SP_LINE, 7, 8'h04);
      tick(); tick();
      reqchk(0, 0, 0, "R4 disabled no req");
      rdchk(SP_LINE, 7, 8'h02, "R4 pending held");
      wr(SP_LINE, 7, 8'h01);
      reqchk(0, 0, 0, "R4 one cycle latency");
      tick();
      reqchk(1, 0, 7, "R4 enabled req");
      ack(); done(7, 0); wr(SP_LINE, 7, 8'h02);

      // R6 hardware set, software clear and set
      irq_in[2] = 1'b1; tick(); irq_in[2] = 1'b0;
      rdchk(SP_LINE, 2, 8'h02, "R6 hw pulse pends");
      wr(SP_LINE, 2, 8'h08);
      rdchk(SP_LINE, 2, 8'h00, "R6 sw clear");
      wr(SP_LINE, 2, 8'h01);
      tick(); tick();
      reqchk(0, 0, 0, "R6 discarded");
      wr(SP_LINE, 2, 8'h04);
      tick();
      reqchk(1, 0, 2, "R6 sw set");
      wr(SP_LINE, 2, 8'h0A);
      tick();

      // R8 global disable
      wr(SP_GLOB, 2, 8'h01);
      wr(SP_LINE, 0, 8'h05);
      tick(); tick();
      reqchk(0, 0, 0, "R8 disable blocks");
      rdchk(SP_LINE, 0, 8'h03, "R8 enable kept");
      wr(SP_GLOB, 2, 8'h00);
      tick();
      reqchk(1, 0, 0, "R8 release");
      wr(SP_LINE, 0, 8'h0A);
      tick();
      reqchk(0, 0, 0, "R8 cleared");

      // R11 non-maskable source
      wr(SP_GLOB, 1, 8'h01); wr(SP_GLOB, 2, 8'h01);
      wr(SP_PRIO, 3, 8'h00); wr(SP_LINE, 3, 8'h05);
      nmi_in = 1'b1; tick(); nmi_in = 1'b0;
      tick();
      reqchk(1, 1, 0, "R11 nmi bypasses gates");
      wr(SP_GLOB, 3, 8'hFE);
      rdchk(SP_GLOB, 3, 8'h01, "R11 not clearable");
      ack();
      rdchk(SP_GLOB, 3, 8'h02, "R11 nmi active");
      wr(SP_GLOB, 2, 8'h00);
      tick(); tick();
      reqchk(0, 0, 0, "R11 nmi active blocks");
      done(0, 1);
      tick();
      reqchk(1, 0, 3, "R12 resume after nmi done");
      ack(); done(3, 0);
      wr(SP_LINE, 3, 8'h0A); wr(SP_GLOB, 1, 8'h00);
      tick();

      // R7 base mask sweep
      for (int m = 0; m < 8; m++) begin
         for (int p = 0; p < 8; p++) begin
            bit e;
            wr(SP_GLOB, 1, 8'(m));
            wr(SP_PRIO, 0, 8'(p << 5));
            wr(SP_LINE, 0, 8'h05);
            tick();
            e = (m == 0) || (p < m);
            reqchk(e, 0, 0, "R7 base mask");
            wr(SP_LINE, 0, 8'h0A);
            tick();
         end
      end
      wr(SP_GLOB, 1, 8'h00);

      // R9 / R10 preemption sweep
      for (int g = 0; g < 8; g++) begin
         for (int r = 0; r < 8; r++) begin
            for (int q = 0; q < 8; q++) begin
               int gb, gm;
               bit e;
               wr(SP_GLOB, 0, 8'(g));
               wr(SP_PRIO, 1, 8'(r << 5));
               wr(SP_LINE, 1, 8'h05);
               tick();
               ack();
               wr(SP_PRIO, 2, 8'(q << 5));
               wr(SP_LINE, 2, 8'h05);
               tick();
               gb = (g > 3) ? 3 : g;
               gm = (8'hFF << (3 - gb)) & 7;
               e  = (q & gm) < (r & gm);
               reqchk(e, 0, 2, (g == 0 || g > 3) ? "R10 grouping" : "R9 preempt");
               wr(SP_LINE, 2, 8'h0A);
               done(1, 0);
               wr(SP_LINE, 1, 8'h0A);
               tick(); tick();
            end
         end
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule